// File: doc/BRIEF.md
# SPI Register Write Master

This block is a single-master serial controller that writes one register in an attached peripheral per command. A host presents an 8-bit register address and an 8-bit value together with a one-cycle start strobe. The controller pulls the active-low select line down, clocks out the sixteen bits with no gap between the address byte and the value byte, and then raises the select line again. Throughout the frame it also shifts in the peripheral's serial output, so the sixteen returned bits are available to the host when the command finishes, whether or not the host needs them.

The serial clock is derived from the system clock. Each half period lasts DIV+1 system cycles, where DIV is a parameter. Clock polarity and clock phase are inputs that the controller captures when it accepts a command, so every one of the four serial modes can be used from one command to the next. The host watches `busy` to see when it may issue the next command, and watches the single-cycle `done` pulse to see when the returned word is ready.

Top module: `spi_regwr_master`

## Requirements
- R1: After reset and whenever no command is running, `cs_n` is 1, `busy` is 0, `done` is 0 and `mosi` is 0.
- R2: Within one command, `cs_n` stays 0 without a break for exactly 32 serial clock transitions (16 full clock cycles), and it rises only in the cycle in which `done` is high.
- R3: The frame carries the address byte and then the value byte, each most significant bit first, so that the 16 bits a peripheral samples form {addr, wdata}.
- R4: With cpha=0, `mosi` already holds address bit 7 in the first cycle of the select window, and the peripheral samples on the odd (leading) transitions. With cpha=1, `mosi` is 0 until the first transition, changes on odd (leading) transitions, and is sampled on even (trailing) transitions.
- R5: While idle, `sclk` rests at the level of `cpol`: low for cpol=0 and high for cpol=1. The first transition of a frame moves away from that level, so in mode 0 (cpol=0, cpha=0) data is sampled on rising edges.
- R6: Between consecutive serial clock transitions there are exactly DIV+1 system clock cycles.
- R7: The first transition comes exactly DIV+1 system cycles after `cs_n` falls, and `cs_n` rises exactly DIV+1 system cycles after the last transition.
- R8: `miso` is sampled on the same transitions as the peripheral samples `mosi`. When `done` is high, `rdata` holds the 16 received bits, with the first bit received at bit 15.
- R9: `done` is high for exactly one system cycle, which is the cycle in which `cs_n` returns to 1, and `mosi` reads 0 from that cycle on.
- R10: A start strobe that arrives while `busy` is 1 is ignored. The running frame keeps its bits, and no second frame follows it.
- R11: `busy` rises in the cycle after an accepted start and falls in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle command strobe |
| addr | input | 8 | Register address, sent first |
| wdata | input | 8 | Register value, sent second |
| cpol | input | 1 | Clock idle level, captured at start |
| cpha | input | 1 | Clock phase, captured at start |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rdata | output | 16 | Bits received on miso during the last frame |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low peripheral select |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The bench plays the peripheral in all four modes and runs 40 commands per mode. Among the operands are all-zeros, all-ones and returned words with only the end bits set. A design that launched data on the wrong transition would shift the captured word by one bit, and a design that sent the least significant bit first would reverse it. The bench measures every gap between transitions, the lead time of the select line and its lag time. A counter that is off by one therefore shows up as a wrong gap or a frame with 30 or 34 transitions. Some frames receive a second start strobe in the middle, which catches a design that reloads its shifter part-way through or starts a phantom second frame.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;

  // Mode captured at command acceptance.
  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  // Number of system cycles in one serial-clock half period.
  function automatic int unsigned half_cycles(input int unsigned div);
    return div + 1;
  endfunction

  // Transition on which the master changes mosi.
  // Transitions are numbered from 1; odd ones are leading edges.
  function automatic logic launch_edge(input logic cpha,
                                       input logic [15:0] num,
                                       input logic [15:0] last);
    if (cpha) return num[0];
    return (!num[0]) && (num != last);
  endfunction

  // Transition on which both sides sample their data input.
  function automatic logic sample_edge(input logic cpha, input logic [15:0] num);
    return cpha ? !num[0] : num[0];
  endfunction

endpackage

// File: rtl/spi_wr_halftick.sv
module spi_wr_halftick #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  import spi_wr_pkg::*;

  localparam int unsigned HALF = half_cycles(DIV);

  generate
    if (HALF == 1) begin : g_every_cycle
      assign tick = run;
    end else begin : g_counter
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt;

      assign tick = run && (cnt == CW'(HALF - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || tick)   cnt <= '0;
        else                     cnt <= cnt + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/spi_wr_seq.sv
module spi_wr_seq #(
  parameter int EDGES = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic             cpol,
  output logic             load,
  output logic             edge_evt,
  output logic             fin_evt,
  output logic [CNT_W-1:0] edge_num,
  output logic             busy,
  output logic             cs_n,
  output logic             done,
  output logic             sclk_q
);

  logic [CNT_W-1:0] tk;

  assign load     = start && !busy;
  assign edge_evt = tick && (tk <  CNT_W'(EDGES));
  assign fin_evt  = tick && (tk == CNT_W'(EDGES));
  assign edge_num = tk + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cs_n   <= 1'b1;
      done   <= 1'b0;
      tk     <= '0;
      sclk_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy   <= 1'b1;
        cs_n   <= 1'b0;
        tk     <= '0;
        sclk_q <= cpol;
      end else if (edge_evt) begin
        tk     <= tk + 1'b1;
        sclk_q <= ~sclk_q;
      end else if (fin_evt) begin
        busy <= 1'b0;
        cs_n <= 1'b1;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_wr_shift.sv
module spi_wr_shift #(
  parameter int BITS  = 16,
  parameter int EDGES = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BITS-1:0]  word,
  input  logic             cpha_ld,
  input  logic             cpha_run,
  input  logic             edge_evt,
  input  logic             fin_evt,
  input  logic [CNT_W-1:0] edge_num,
  input  logic             miso,
  output logic             mosi,
  output logic [BITS-1:0]  rx
);
  import spi_wr_pkg::*;

  logic [BITS-1:0] tx;
  logic            mosi_q;
  logic            launch;
  logic            sample;

  assign launch = edge_evt && launch_edge(cpha_run, 16'(edge_num), 16'(EDGES));
  assign sample = edge_evt && sample_edge(cpha_run, 16'(edge_num));
  assign mosi   = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx     <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      if (cpha_ld) begin
        mosi_q <= 1'b0;
        tx     <= word;
      end else begin
        mosi_q <= word[BITS-1];
        tx     <= word << 1;
      end
    end else if (launch) begin
      mosi_q <= tx[BITS-1];
      tx     <= tx << 1;
    end else if (fin_evt) begin
      mosi_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx <= '0;
    else if (sample) rx <= {rx[BITS-2:0], miso};
  end

endmodule

// File: rtl/spi_regwr_master.sv
module spi_regwr_master #(
  parameter int DIV    = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       cpol,
  input  logic                       cpha,
  output logic                       busy,
  output logic                       done,
  output logic [ADDR_W+DATA_W-1:0]   rdata,
  output logic                       sclk,
  output logic                       cs_n,
  output logic                       mosi,
  input  logic                       miso
);
  import spi_wr_pkg::*;

  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int EDGES      = 2 * FRAME_BITS;
  localparam int CNT_W      = $clog2(EDGES + 2);

  logic             tick;
  logic             load;
  logic             edge_evt;
  logic             fin_evt;
  logic [CNT_W-1:0] edge_num;
  logic             sclk_q;
  spi_mode_t        mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= '0;
    else if (load) mode_q <= '{cpol: cpol, cpha: cpha};
  end

  spi_wr_halftick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  spi_wr_seq #(.EDGES(EDGES), .CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tick    (tick),
    .cpol    (cpol),
    .load    (load),
    .edge_evt(edge_evt),
    .fin_evt (fin_evt),
    .edge_num(edge_num),
    .busy    (busy),
    .cs_n    (cs_n),
    .done    (done),
    .sclk_q  (sclk_q)
  );

  spi_wr_shift #(.BITS(FRAME_BITS), .EDGES(EDGES), .CNT_W(CNT_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .word    ({addr, wdata}),
    .cpha_ld (cpha),
    .cpha_run(mode_q.cpha),
    .edge_evt(edge_evt),
    .fin_evt (fin_evt),
    .edge_num(edge_num),
    .miso    (miso),
    .mosi    (mosi),
    .rx      (rdata)
  );

  // Idle level follows the polarity input; during a frame the toggling copy.
  assign sclk = busy ? sclk_q : cpol;

endmodule

// File: rtl/spi_regwr_chk.sv
module spi_regwr_chk #(
  parameter int FRAME_BITS = 16,
  parameter int DIV        = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic edge_evt
);
  localparam int EDGES = 2 * FRAME_BITS;
  localparam int TW    = $clog2(EDGES + 2) + 1;
  localparam int GW    = $clog2(DIV + 3) + 1;

  logic          sclk_prev;
  logic [TW-1:0] toggles;
  logic [GW-1:0] gap;
  logic          moved;

  assign moved = (sclk != sclk_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      toggles   <= '0;
      gap       <= '0;
    end else begin
      sclk_prev <= sclk;
      if (cs_n) begin
        toggles <= '0;
        gap     <= '0;
      end else begin
        if (moved) toggles <= toggles + 1'b1;
        if (moved) gap <= GW'(1);
        else if (gap != {GW{1'b1}}) gap <= gap + 1'b1;
      end
    end
  end

  AST_IDLE_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);                                                   // R1
  AST_MOSI_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);                                                   // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R9
  AST_DONE_WITH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));                                             // R9
  AST_RISE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);                                             // R2
  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (toggles == TW'(EDGES)));                                 // R2
  AST_EDGE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |-> !cs_n);                                               // R2
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && moved) |-> (gap == GW'(DIV + 1)));                       // R6
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                             // R11

endmodule

bind spi_regwr_master spi_regwr_chk #(.FRAME_BITS(FRAME_BITS), .DIV(DIV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .sclk    (sclk),
  .mosi    (mosi),
  .busy    (busy),
  .done    (done),
  .edge_evt(edge_evt)
);

// File: tb/spi_regwr_master_test.sv
`timescale 1ns/1ps
module spi_regwr_master_test;
  localparam int DIV = 2;
  localparam int H   = DIV + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        cpol_i = 1'b0;
  logic        cpha_i = 1'b0;
  logic        miso = 1'b0;
  logic        busy, done, sclk, cs_n, mosi;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  spi_regwr_master #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr_i), .wdata(data_i),
    .cpol(cpol_i), .cpha(cpha_i), .busy(busy), .done(done), .rdata(rdata),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic frame(input bit cp, input bit ch, input logic [7:0] a,
                       input logic [7:0] d, input logic [15:0] s, input bit poke);
    logic [15:0] got;
    logic [15:0] sh;
    int cyc, last, edges, lead, ends;
    bit  gaps_ok, busy_ok, dir_ok;
    @(negedge clk);
    cpol_i = cp; cpha_i = ch;
    @(negedge clk);
    check("R5", "idle sclk level", 32'(sclk), 32'(cp));
    check("R1", "idle cs_n/busy/mosi", {29'd0, cs_n, busy, mosi}, 32'b100);
    addr_i = a; data_i = d; start = 1'b1;
    if (ch) begin miso = 1'b0; sh = s; end
    else    begin miso = s[15]; sh = s << 1; end
    @(negedge clk);
    start = 1'b0;
    check("R11", "busy/cs_n after start", {30'd0, busy, cs_n}, 32'b10);
    check("R4", "mosi before first edge", 32'(mosi), ch ? 32'd0 : 32'(a[7]));
    got = '0; cyc = 0; last = 0; edges = 0; lead = 0; ends = 0;
    gaps_ok = 1; busy_ok = 1; dir_ok = 1;
    while (cyc < 2000) begin
      logic prev;
      prev = sclk;
      @(negedge clk);
      cyc++;
      if (poke && cyc == 20) begin start = 1'b1; addr_i = ~a; data_i = ~d; end
      if (poke && cyc == 21) begin start = 1'b0; addr_i = a; data_i = d; end
      if (cs_n) begin ends = cyc; break; end
      if (!busy || done) busy_ok = 0;
      if (sclk != prev) begin
        edges++;
        if (edges == 1) begin
          lead = cyc - last;
          if (sclk != !cp) dir_ok = 0;
        end else if (cyc - last != H) gaps_ok = 0;
        last = cyc;
        if (ch ? (edges % 2 == 0) : (edges % 2 == 1)) got = {got[14:0], mosi};
        if (ch ? (edges % 2 == 1) : (edges % 2 == 0)) begin
          miso = sh[15]; sh = sh << 1;
        end
      end
    end
    check("R2", "transitions in select window", 32'(edges), 32'd32);
    check("R3", "word sampled by peripheral", 32'(got), {16'd0, a, d});
    check("R5", "first transition leaves idle level", 32'(dir_ok), 32'd1);
    check("R6", "every half period", 32'(gaps_ok), 32'd1);
    check("R7", "select lead", 32'(lead), 32'(H));
    check("R7", "select lag", 32'(ends - last), 32'(H));
    check("R8", "received word", 32'(rdata), 32'(s));
    check("R9", "done/mosi at select rise", {30'd0, done, mosi}, 32'b10);
    check("R11", "busy through frame, low at end", {30'd0, busy_ok, busy}, 32'b10);
    @(negedge clk);
    check("R9", "done width", 32'(done), 32'd0);
    if (poke) begin
      bit quiet;
      quiet = 1;
      for (int k = 0; k < 3 * H; k++) begin
        @(negedge clk);
        if (!cs_n || busy) quiet = 0;
      end
      check("R10", "no frame after ignored strobe", 32'(quiet), 32'd1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 to R11: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset cs_n/busy/done/mosi",
          {28'd0, cs_n, busy, done, mosi}, 32'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after release", {28'd0, cs_n, busy, done, mosi}, 32'b1000);
    check("R5", "idle sclk after reset", 32'(sclk), 32'(cpol_i));
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 40; i++) begin
        logic [7:0]  a, d;
        logic [15:0] s;
        a = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 37 + 11);
        d = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 91) ^ 8'hA5);
        s = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF :
            (i == 2) ? 16'h8001 : 16'((i * 4099) ^ 16'h3C5A);
        frame(m[1], m[0], a, d, s, (i % 7) == 3);
      end
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule